// File: doc/BRIEF.md
# Register Window Address Decoder

This block sits on a byte-wide asynchronous host memory bus, between the host and an external SRAM. It watches a 19-bit address. The sixteen highest locations of that space form a window that belongs to an internal register file. The SRAM never sees those locations. For every other address, the host chip-enable and output-enable go straight through to the SRAM. When the address is inside the window, both SRAM enables are held inactive. Reads are then answered from a register-file read port, and writes are passed on as a single-cycle write strobe with a captured index and data byte.

The data bus is not a tri-state pad inside the core. It is modelled as a drive-enable flag plus the output byte, and the pad sits outside. Two condition flags come in from outside the core: power-fail and reset-hold. While either flag is high, the block denies all access, to the SRAM and to the registers alike. Host inputs are assumed to be synchronised to `clk` before they reach this block.

Top module: `regwin_decoder`

## Requirements
- R1: An address is inside the window exactly when address bits 18..4 are all ones (0x7FFF0 through 0x7FFFF). `reg_rd_idx` always equals address bits 3..0.
- R2: While the address is inside the window, `sram_ce_n` and `sram_oe_n` are both 1.
- R3: While the address is outside the window and access is not blocked, `sram_ce_n` equals `host_ce_n` and `sram_oe_n` equals `host_oe_n`.
- R4: `bus_drive` is 1 only when all of the following hold: the address is inside the window, `host_ce_n`=0, `host_oe_n`=0, `host_we_n`=1, and access is not blocked. While `bus_drive` is 1, `bus_rdata` equals `reg_rdata`; otherwise `bus_rdata` is 0.
- R5: When `host_we_n` is 0, `bus_drive` is 0 even if chip-enable and output-enable are both low.
- R6: A window write is active while the address is inside the window, `host_ce_n`=0, `host_we_n`=0 and access is not blocked. `reg_wr` is 1 for the one clock period that follows the last rising clock edge at which a window write was active, once that write is no longer active.
- R7: During a strobe, `reg_wr_idx` and `reg_wr_data` carry address bits 3..0 and `host_wdata` as sampled at the last rising edge at which the window write was active.
- R8: While `pwr_fail` or `por_hold` is 1, the following all hold: both SRAM enables are 1, `bus_drive` is 0, and `reg_wr` is 0. A window write that is cut short by blocking produces no strobe.
- R9: After a synchronous active-low reset, `reg_wr` is 0 and `reg_wr_idx` and `reg_wr_data` are 0.
- R10: A write to an address outside the window produces no `reg_wr` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 19 | Host address |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_wdata | input | 8 | Write data from the host bus |
| pwr_fail | input | 1 | Supply is below the power-fail point |
| por_hold | input | 1 | Reset output is being asserted |
| reg_rdata | input | 8 | Read data from the register file at `reg_rd_idx` |
| sram_ce_n | output | 1 | SRAM chip-enable, active low |
| sram_oe_n | output | 1 | SRAM output-enable, active low |
| bus_drive | output | 1 | The block drives the data bus |
| bus_rdata | output | 8 | Byte driven onto the data bus |
| reg_rd_idx | output | 4 | Register read index |
| reg_wr | output | 1 | Register write strobe |
| reg_wr_idx | output | 4 | Register write index |
| reg_wr_data | output | 8 | Register write data |

## Verification
The hardest case to reach from the ports is a window write that is cut short by power-fail or reset-hold. The bench has to prove that the write leaves no strobe behind once blocking ends, and that its captured index does not show up later. Uniform random addresses would almost never land inside the sixteen-location window, so half the random addresses are forced into it. The blocking flags are raised in about one cycle in eight, which makes writes interrupted by blocking common. Directed sequences then cover the remaining cases: a write truncated by blocking, the boundary addresses on both sides of the window, and output-enable held low while write-enable falls.

// File: rtl/regwin_pkg.sv
// Shared definitions for the register window decoder.
// Assumes nothing beyond the default bus widths listed here.
package regwin_pkg;
    localparam int unsigned ADDR_W_DEF = 19;
    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned IDX_W_DEF  = 4;

    // Kind of host bus cycle seen on the control lines.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Classify the host control lines (write wins over read).
    function automatic acc_kind_e classify(input logic ce_n, input logic we_n);
        if (ce_n)      return ACC_IDLE;
        else if (!we_n) return ACC_WRITE;
        else           return ACC_READ;
    endfunction
endpackage

// File: rtl/regwin_match.sv
// Address comparator for the register window.
// The window is the top 2**IDX_W locations of the address space.
// Assumes ADDR_W > IDX_W.
module regwin_match #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] tag;

    // Split the address into the compared tag and the register index.
    always_comb begin
        tag = addr[ADDR_W-1:IDX_W];
        idx = addr[IDX_W-1:0];
        hit = &tag;
    end
endmodule

// File: rtl/regwin_gate.sv
// Combinational enable steering and data-drive control.
// Sends the host enables to the SRAM or suppresses them, and decides
// when the register read data is driven onto the bus.
// Assumes the blocked flag is already the OR of all the inhibit sources.
module regwin_gate #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              hit,
    input  logic              blocked,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              bus_drive,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              win_wr_act
);
    import regwin_pkg::*;

    acc_kind_e kind;

    // Hold the SRAM off on a window hit or while blocked; otherwise pass through.
    always_comb begin
        sram_ce_n = ce_n | hit | blocked;
        sram_oe_n = oe_n | hit | blocked;
    end

    // Drive read data only for an unblocked window read with output-enable low.
    always_comb begin
        kind       = classify(ce_n, we_n);
        bus_drive  = hit && !blocked && !oe_n && (kind == ACC_READ);
        bus_rdata  = bus_drive ? reg_rdata : '0;
        win_wr_act = hit && !blocked && (kind == ACC_WRITE);
    end
endmodule

// File: rtl/regwin_wstrobe.sv
// Write strobe generator for the register window.
// Samples the window-write condition every clock, keeps the index and
// data of the latest active cycle, and issues one strobe when the
// condition ends. Blocking cancels a pending strobe.
// Assumes host inputs are synchronous to clk.
module regwin_wstrobe #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_wr_act,
    input  logic              blocked,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data
);
    logic wr_q;

    // Track the window-write condition and capture its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q        <= 1'b0;
            reg_wr_idx  <= '0;
            reg_wr_data <= '0;
        end else begin
            wr_q <= win_wr_act;
            if (win_wr_act) begin
                reg_wr_idx  <= idx;
                reg_wr_data <= wdata;
            end
        end
    end

    // Strobe on the end of an active window, unless blocking cut it off.
    always_comb begin
        reg_wr = wr_q && !win_wr_act && !blocked;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R6
    AST_STROBE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(win_wr_act)); // R6
    AST_STROBE_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !reg_wr); // R8
endmodule

// File: rtl/regwin_decoder.sv
// Top of the register window decoder.
// Places a register window at the top of the SRAM address space, steers
// the SRAM enables and the data drive, and generates register write
// strobes. Every access is inhibited while power-fail or reset-hold is high.
// Assumes host bus inputs are already synchronised to clk.
module regwin_decoder #(
    parameter int unsigned ADDR_W = regwin_pkg::ADDR_W_DEF,
    parameter int unsigned DATA_W = regwin_pkg::DATA_W_DEF,
    parameter int unsigned IDX_W  = regwin_pkg::IDX_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              pwr_fail,
    input  logic              por_hold,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              bus_drive,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  reg_rd_idx,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data
);
    logic hit;
    logic blocked;
    logic win_wr_act;

    // Merge the inhibit sources into one blocking flag.
    always_comb blocked = pwr_fail | por_hold;

    regwin_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .addr (host_addr),
        .hit  (hit),
        .idx  (reg_rd_idx)
    );

    regwin_gate #(.DATA_W(DATA_W)) u_gate (
        .hit        (hit),
        .blocked    (blocked),
        .ce_n       (host_ce_n),
        .oe_n       (host_oe_n),
        .we_n       (host_we_n),
        .reg_rdata  (reg_rdata),
        .sram_ce_n  (sram_ce_n),
        .sram_oe_n  (sram_oe_n),
        .bus_drive  (bus_drive),
        .bus_rdata  (bus_rdata),
        .win_wr_act (win_wr_act)
    );

    regwin_wstrobe #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_wstrobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_wr_act  (win_wr_act),
        .blocked     (blocked),
        .idx         (reg_rd_idx),
        .wdata       (host_wdata),
        .reg_wr      (reg_wr),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data)
    );

    AST_HIT_HOLDS_SRAM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sram_ce_n && sram_oe_n)); // R2
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !blocked) |-> (sram_ce_n == host_ce_n && sram_oe_n == host_oe_n)); // R3
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (host_we_n && hit)); // R5
    AST_BLOCK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (sram_ce_n && sram_oe_n && !bus_drive)); // R8
endmodule

// File: tb/test_regwin_decoder.sv
// Self-checking bench for regwin_decoder: seeded random plus directed cases.
module test_regwin_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] host_addr;
    logic        host_ce_n, host_oe_n, host_we_n;
    logic [7:0]  host_wdata;
    logic        pwr_fail, por_hold;
    logic [7:0]  reg_rdata;
    logic        sram_ce_n, sram_oe_n, bus_drive, reg_wr;
    logic [7:0]  bus_rdata, reg_wr_data;
    logic [3:0]  reg_rd_idx, reg_wr_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Bench model of the strobe state.
    bit         m_wq;
    logic [3:0] m_idx;
    logic [7:0] m_dat;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_decoder i_regwin_decoder (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_wdata(host_wdata), .pwr_fail(pwr_fail), .por_hold(por_hold),
        .reg_rdata(reg_rdata), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .bus_drive(bus_drive), .bus_rdata(bus_rdata), .reg_rd_idx(reg_rd_idx),
        .reg_wr(reg_wr), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data)
    );

    function automatic bit f_hit(input logic [18:0] a);
        return a >= 19'h7FFF0;
    endfunction

    function automatic bit f_blk();
        return pwr_fail || por_hold;
    endfunction

    function automatic bit f_wact();
        return f_hit(host_addr) && !f_blk() && !host_ce_n && !host_we_n;
    endfunction

    function automatic bit f_drive();
        return f_hit(host_addr) && !f_blk() && !host_ce_n && !host_oe_n && host_we_n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h addr=%05h", req, act, exp, host_addr);
        end
    endtask

    // Compare every output with the model, then advance one clock.
    task automatic step();
        bit h, b, d;
        #1;
        h = f_hit(host_addr);
        b = f_blk();
        d = f_drive();
        chk("R1", reg_rd_idx, host_addr[3:0]);
        if (b) begin
            chk("R8 ce", sram_ce_n, 1);
            chk("R8 oe", sram_oe_n, 1);
        end else if (h) begin
            chk("R2 ce", sram_ce_n, 1);
            chk("R2 oe", sram_oe_n, 1);
        end else begin
            chk("R3 ce", sram_ce_n, host_ce_n);
            chk("R3 oe", sram_oe_n, host_oe_n);
        end
        if (h && !host_oe_n && !host_ce_n && !host_we_n) chk("R5", bus_drive, 0);
        else chk("R4 drive", bus_drive, d);
        chk("R4 data", bus_rdata, d ? reg_rdata : 8'h00);
        chk("R6", reg_wr, m_wq && !f_wact() && !b);
        if (reg_wr) begin
            chk("R7 idx", reg_wr_idx, m_idx);
            chk("R7 data", reg_wr_data, m_dat);
        end
        @(posedge clk);
        if (f_wact()) begin
            m_idx = host_addr[3:0];
            m_dat = host_wdata;
        end
        m_wq = f_wact();
        @(negedge clk);
    endtask

    task automatic drive(input logic [18:0] a, input bit ce, input bit oe,
                         input bit we, input logic [7:0] wd, input bit pf, input bit ph);
        host_addr = a; host_ce_n = ce; host_oe_n = oe; host_we_n = we;
        host_wdata = wd; pwr_fail = pf; por_hold = ph;
        reg_rdata = 8'(a[3:0] * 17 + 3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        rst_n = 1'b0;
        m_wq = 0; m_idx = '0; m_dat = '0;
        drive(19'h7FFF5, 0, 1, 0, 8'hAA, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset clears the strobe and its captured values.
        chk("R9 wr", reg_wr, 0);
        chk("R9 idx", reg_wr_idx, 0);
        chk("R9 data", reg_wr_data, 0);
        drive(19'h00000, 1, 1, 1, 8'h00, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        m_wq = 0;
        step();

        // Window write at 0x7FFF3 (R6, R7).
        drive(19'h7FFF3, 0, 1, 0, 8'h5C, 0, 0); step(); step();
        drive(19'h7FFF3, 1, 1, 1, 8'h00, 0, 0);
        #1 chk("R6 strobe", reg_wr, 1);
        chk("R7 idx", reg_wr_idx, 4'h3);
        chk("R7 data", reg_wr_data, 8'h5C);
        step(); step();
        // Boundary addresses around the window (R1, R2, R3).
        drive(19'h7FFEF, 0, 0, 1, 8'h00, 0, 0);
        #1 chk("R3 below window", sram_ce_n, 0);
        step();
        drive(19'h7FFF0, 0, 0, 1, 8'h00, 0, 0);
        #1 chk("R2 lowest window", sram_ce_n, 1);
        chk("R4 read low", bus_drive, 1);
        step();
        drive(19'h7FFFF, 0, 0, 1, 8'h00, 0, 0);
        #1 chk("R4 read top", bus_rdata, 8'(15 * 17 + 3));
        step();
        // Output-enable low while write-enable falls (R5).
        drive(19'h7FFFF, 0, 0, 0, 8'h11, 0, 0);
        #1 chk("R5 drive off", bus_drive, 0);
        step();
        drive(19'h00000, 1, 1, 1, 8'h00, 0, 0); step(); step();
        // Write outside the window (R10).
        drive(19'h12345, 0, 1, 0, 8'h77, 0, 0); step();
        drive(19'h12345, 1, 1, 1, 8'h00, 0, 0);
        #1 chk("R10 no strobe", reg_wr, 0);
        step();
        // Window write cut short by power-fail (R8).
        drive(19'h7FFF9, 0, 1, 0, 8'hE1, 0, 0); step();
        drive(19'h7FFF9, 0, 1, 0, 8'hE1, 1, 0);
        #1 chk("R8 cut", reg_wr, 0);
        step();
        drive(19'h7FFF9, 1, 1, 1, 8'h00, 0, 0);
        #1 chk("R8 no late strobe", reg_wr, 0);
        step();
        drive(19'h7FFF2, 0, 0, 1, 8'h00, 0, 1);
        #1 chk("R8 reset-hold drive", bus_drive, 0);
        step();

        // Seeded random traffic, half of it inside the window.
        for (int i = 0; i < 3000; i++) begin
            logic [18:0] a;
            a = 19'($urandom);
            if ($urandom_range(1, 0) == 1) a = {15'h7FFF, a[3:0]};
            drive(a, 1'($urandom_range(3, 0) == 0 ? 1 : 0), 1'($urandom), 1'($urandom),
                  8'($urandom), 1'($urandom_range(15, 0) == 0),
                  1'($urandom_range(15, 0) == 0));
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule